// File: doc/BRIEF.md
# Codec Register Loader over I2C

This block brings an audio codec into a known configuration as soon as the chip leaves reset. It holds the bus idle for a settling period, then writes a list of configuration words to the codec over a two-wire I2C bus. Each word comes from a lookup table that the loader addresses with an index. The table returns a 24-bit word and the number of words it holds.

Each 24-bit word becomes one I2C write: a start condition, three bytes that the codec must acknowledge, and a stop condition. A write that is not fully acknowledged is repeated from a fresh start. Once the last word has gone out, a done flag rises and stays high, and the bus stays idle.

A companion table module holds the ten words used for a typical line-in to headphone setup. It sits next to the loader and connects through the index, word and size signals.

Top module: `codec_cfg_seq`

## Requirements
- R1: After reset is released, `scl` stays high, `sda` stays released, `tblIndex` stays 0 and `cfgDone` stays low for at least WAIT_CYCLES clock cycles, and no start condition occurs before then.
- R2: Each table word is sent as one transaction. It starts with a start condition (`sda` falls while `scl` is high) and ends with a stop condition (`sda` rises while `scl` is high). In between come the three bytes `tblEntry[23:16]`, `tblEntry[15:8]` and `tblEntry[7:0]`, in that order and most significant bit first, each followed by one acknowledge clock.
- R3: The `scl` period inside a transaction is 4*QUARTER_DIV clock cycles, and `scl` is high for 2*QUARTER_DIV of them. QUARTER_DIV is CLK_HZ/(4*SCL_HZ), which is 125 at the defaults (50 MHz to 100 kHz).
- R4: `sda` and `scl` never change in the same clock cycle. Data bits change only while `scl` is low.
- R5: The block only ever pulls `sda` low. It releases the line for a 1 bit and for the whole acknowledge clock, so a target that does not acknowledge is read back as high.
- R6: If `sda` is high when the acknowledge clock is sampled, the block skips the remaining bytes and issues a stop. It then restarts the same word with `tblIndex` unchanged.
- R7: `tblIndex` starts at 0 and only ever moves up by one. It advances only after all three bytes of a word have been acknowledged, and it stays below `tblSize` while `cfgDone` is low.
- R8: After the stop of the word at index `tblSize`-1, `cfgDone` rises and stays high. From then on `scl` and `sda` stay high and no further start occurs. With `tblSize` 0, `cfgDone` rises after the wait and no transaction takes place.
- R9: The table module reports a size of 10. Every one of its ten words carries the write address byte 0x34 in bits [23:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (CLK_HZ) |
| rstN | input | 1 | Active-low synchronous reset |
| tblIndex | output | IDX_W | Index of the table word being written |
| tblEntry | input | 24 | Table word at `tblIndex`: address byte and two register bytes |
| tblSize | input | IDX_W | Number of words in the table |
| scl | output | 1 | I2C clock, high when idle |
| sda | inout | 1 | I2C data; driven low or released to high impedance |
| cfgDone | output | 1 | All words written; stays high until reset |

## Verification
The bench acts as the codec on the bus. It serves words with all-ones, all-zeros and alternating bit patterns, so that a byte-order swap or a bit-order reversal shows up as a wrong byte. A withheld acknowledge on the address byte, on a middle byte and on the last byte of different words tells apart a retry that re-sends the right word, a retry that moves the index on, and an abort that keeps clocking bytes. Three table sizes are used: six words, one word and an empty table. These separate the normal stepping through the table, the case where the first word is also the last, and the path that raises done with no bus traffic.

// File: rtl/codec_cfg_pkg.sv
package codec_cfg_pkg;

  localparam int BYTE_W      = 8;
  localparam int ENTRY_BYTES = 3;
  localparam int ENTRY_W     = BYTE_W * ENTRY_BYTES;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_START,
    ST_BIT,
    ST_ACK,
    ST_STOP,
    ST_DONE
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic runDiv;
    logic loadFirst;
    logic nextByte;
    logic shiftBit;
    logic advIndex;
  } seqStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic       tickQ;
    logic [1:0] qPhase;
    logic       txBit;
    logic       lastBit;
    logic       lastByte;
    logic       lastEntry;
    logic       emptyTable;
    logic       waitDone;
  } dpStatus_t;

  function automatic logic [BYTE_W-1:0] pickByte(input logic [ENTRY_W-1:0] word,
                                                 input logic [1:0] sel);
    case (sel)
      2'd0:    return word[ENTRY_W-1 -: BYTE_W];
      2'd1:    return word[ENTRY_W-BYTE_W-1 -: BYTE_W];
      default: return word[BYTE_W-1:0];
    endcase
  endfunction

endpackage

// File: rtl/codec_reg_table.sv
module codec_reg_table #(
  parameter int         IDX_W    = 4,
  parameter logic [6:0] DEV_ADDR = 7'h1A
) (
  input  logic [IDX_W-1:0] idx,
  output logic [23:0]      entry,
  output logic [IDX_W-1:0] size
);
  localparam int ENTRY_COUNT = 10;

  logic [15:0] regWord;

  // each word: 7-bit register number, 9-bit value
  always_comb begin
    case (idx)
      IDX_W'(0): regWord = {7'h0F, 9'h000};
      IDX_W'(1): regWord = {7'h00, 9'h017};
      IDX_W'(2): regWord = {7'h01, 9'h017};
      IDX_W'(3): regWord = {7'h02, 9'h079};
      IDX_W'(4): regWord = {7'h03, 9'h079};
      IDX_W'(5): regWord = {7'h04, 9'h012};
      IDX_W'(6): regWord = {7'h05, 9'h000};
      IDX_W'(7): regWord = {7'h06, 9'h000};
      IDX_W'(8): regWord = {7'h07, 9'h002};
      IDX_W'(9): regWord = {7'h09, 9'h001};
      default:   regWord = 16'h0000;
    endcase
  end

  assign entry = {DEV_ADDR, 1'b0, regWord};
  assign size  = IDX_W'(ENTRY_COUNT);

endmodule

// File: rtl/codec_cfg_dp.sv
module codec_cfg_dp
  import codec_cfg_pkg::*;
#(
  parameter int QUARTER_DIV = 125,
  parameter int WAIT_CYCLES = 50000,
  parameter int IDX_W       = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         stb,
  input  logic [ENTRY_W-1:0] entry,
  input  logic [IDX_W-1:0]   size,
  output logic [IDX_W-1:0]   idx,
  output dpStatus_t          st
);
  localparam int DIV_W  = (QUARTER_DIV > 1) ? $clog2(QUARTER_DIV) : 1;
  localparam int WAIT_W = $clog2(WAIT_CYCLES + 1);
  localparam int BCNT_W = $clog2(BYTE_W);

  logic [DIV_W-1:0]  divCnt;
  logic [1:0]        qPhase;
  logic              tickQ;
  logic [WAIT_W-1:0] waitCnt;
  logic              waitDone;
  logic [BYTE_W-1:0] shReg;
  logic [BCNT_W-1:0] bitCnt;
  logic [1:0]        byteSel;

  assign tickQ = stb.runDiv && (divCnt == DIV_W'(QUARTER_DIV - 1));

  // quarter-period timebase
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      qPhase <= '0;
    end else if (!stb.runDiv) begin
      divCnt <= '0;
      qPhase <= '0;
    end else if (tickQ) begin
      divCnt <= '0;
      qPhase <= qPhase + 2'd1;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  // settling wait after reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt  <= '0;
      waitDone <= 1'b0;
    end else if (!waitDone) begin
      if (waitCnt == WAIT_W'(WAIT_CYCLES - 1)) waitDone <= 1'b1;
      else                                     waitCnt  <= waitCnt + WAIT_W'(1);
    end
  end

  // byte shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg   <= '0;
      bitCnt  <= '0;
      byteSel <= '0;
    end else if (stb.loadFirst) begin
      shReg   <= pickByte(entry, 2'd0);
      bitCnt  <= '0;
      byteSel <= 2'd0;
    end else if (stb.nextByte) begin
      shReg   <= pickByte(entry, byteSel + 2'd1);
      bitCnt  <= '0;
      byteSel <= byteSel + 2'd1;
    end else if (stb.shiftBit) begin
      shReg   <= {shReg[BYTE_W-2:0], 1'b0};
      bitCnt  <= bitCnt + BCNT_W'(1);
    end
  end

  // table index
  always_ff @(posedge clk) begin
    if (!rstN)             idx <= '0;
    else if (stb.advIndex) idx <= idx + IDX_W'(1);
  end

  always_comb begin
    st.tickQ      = tickQ;
    st.qPhase     = qPhase;
    st.txBit      = shReg[BYTE_W-1];
    st.lastBit    = (bitCnt == BCNT_W'(BYTE_W - 1));
    st.lastByte   = (byteSel == 2'(ENTRY_BYTES - 1));
    st.lastEntry  = (idx == size - IDX_W'(1));
    st.emptyTable = (size == '0);
    st.waitDone   = waitDone;
  end

endmodule

// File: rtl/codec_cfg_ctrl.sv
module codec_cfg_ctrl
  import codec_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStatus_t  st,
  input  logic       sdaIn,
  output seqStrobe_t stb,
  output logic       sclOut,
  output logic       sdaLowOut,
  output logic       done
);
  seqState_e state, stateNx;
  logic      ackOk;
  logic      nackSeen;
  logic      endSlot;
  logic      sclNx;
  logic      sdaRelNx;

  // a slot is four quarters; state moves only at its end
  assign endSlot = st.tickQ && (st.qPhase == 2'd3);

  always_comb begin
    stateNx    = state;
    stb        = '0;
    stb.runDiv = (state == ST_START) || (state == ST_BIT) ||
                 (state == ST_ACK)   || (state == ST_STOP);
    case (state)
      ST_WAIT:
        if (st.waitDone) stateNx = st.emptyTable ? ST_DONE : ST_START;
      ST_START:
        if (endSlot) begin
          stb.loadFirst = 1'b1;
          stateNx       = ST_BIT;
        end
      ST_BIT:
        if (endSlot) begin
          stb.shiftBit = 1'b1;
          if (st.lastBit) stateNx = ST_ACK;
        end
      ST_ACK:
        if (endSlot) begin
          if (!ackOk || st.lastByte) begin
            stateNx = ST_STOP;
          end else begin
            stb.nextByte = 1'b1;
            stateNx      = ST_BIT;
          end
        end
      ST_STOP:
        if (endSlot) begin
          if (nackSeen) begin
            stateNx = ST_START;
          end else if (st.lastEntry) begin
            stateNx = ST_DONE;
          end else begin
            stb.advIndex = 1'b1;
            stateNx      = ST_START;
          end
        end
      default: stateNx = state;
    endcase
  end

  // bus levels per quarter
  always_comb begin
    sclNx    = 1'b1;
    sdaRelNx = 1'b1;
    case (state)
      ST_START: begin
        sclNx    = (st.qPhase != 2'd3);
        sdaRelNx = !st.qPhase[1];
      end
      ST_BIT: begin
        sclNx    = (st.qPhase == 2'd1) || (st.qPhase == 2'd2);
        sdaRelNx = st.txBit;
      end
      ST_ACK: begin
        sclNx    = (st.qPhase == 2'd1) || (st.qPhase == 2'd2);
        sdaRelNx = 1'b1;
      end
      ST_STOP: begin
        sclNx    = (st.qPhase != 2'd0);
        sdaRelNx = st.qPhase[1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_WAIT;
      ackOk     <= 1'b0;
      nackSeen  <= 1'b0;
      sclOut    <= 1'b1;
      sdaLowOut <= 1'b0;
      done      <= 1'b0;
    end else begin
      state     <= stateNx;
      sclOut    <= sclNx;
      sdaLowOut <= !sdaRelNx;
      done      <= (state == ST_DONE);
      if (state == ST_ACK && st.tickQ && st.qPhase == 2'd2) ackOk <= !sdaIn;
      if (state == ST_ACK && endSlot) nackSeen <= !ackOk;
    end
  end

endmodule

// File: rtl/codec_cfg_seq.sv
module codec_cfg_seq
  import codec_cfg_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int SCL_HZ      = 100_000,
  parameter int WAIT_CYCLES = 50_000,
  parameter int IDX_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [IDX_W-1:0] tblIndex,
  input  logic [23:0]      tblEntry,
  input  logic [IDX_W-1:0] tblSize,
  output logic             scl,
  inout  wire              sda,
  output logic             cfgDone
);
  localparam int QUARTER_DIV = CLK_HZ / (4 * SCL_HZ);

  seqStrobe_t stb;
  dpStatus_t  dpSt;
  logic       sdaLow;
  logic       sdaIn;

  assign sda   = sdaLow ? 1'b0 : 1'bz;
  assign sdaIn = sda;

  codec_cfg_dp #(
    .QUARTER_DIV(QUARTER_DIV),
    .WAIT_CYCLES(WAIT_CYCLES),
    .IDX_W      (IDX_W)
  ) uDp (
    .clk  (clk),
    .rstN (rstN),
    .stb  (stb),
    .entry(tblEntry),
    .size (tblSize),
    .idx  (tblIndex),
    .st   (dpSt)
  );

  codec_cfg_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .st       (dpSt),
    .sdaIn    (sdaIn),
    .stb      (stb),
    .sclOut   (scl),
    .sdaLowOut(sdaLow),
    .done     (cfgDone)
  );

endmodule

// File: rtl/codec_cfg_seq_chk.sv
module codec_cfg_seq_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             scl,
  input logic             sdaLow,
  input logic             cfgDone,
  input logic             waitDone,
  input logic [IDX_W-1:0] tblIndex,
  input logic [IDX_W-1:0] tblSize
);

  p_quiet_wait_r1: assert property (@(posedge clk) disable iff (!rstN)
    !waitDone |-> (scl && !sdaLow && !cfgDone && tblIndex == '0));

  p_no_joint_edge_r4: assert property (@(posedge clk) disable iff (!rstN)
    (scl != $past(scl)) |-> (sdaLow == $past(sdaLow)));

  p_index_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (tblIndex == $past(tblIndex) || tblIndex == $past(tblIndex) + IDX_W'(1)));

  p_index_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgDone && tblSize != '0) |-> (tblIndex < tblSize));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |=> cfgDone);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |-> (scl && !sdaLow));

endmodule

bind codec_cfg_seq codec_cfg_seq_chk #(.IDX_W(IDX_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .scl     (scl),
  .sdaLow  (sdaLow),
  .cfgDone (cfgDone),
  .waitDone(dpSt.waitDone),
  .tblIndex(tblIndex),
  .tblSize (tblSize)
);

// File: tb/tb_codec_cfg_seq.sv
module tb_codec_cfg_seq;
  localparam int QD    = 5;
  localparam int WAITC = 200;
  localparam int IDX_W = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [IDX_W-1:0] tblIndex;
  logic [23:0]      tblEntry;
  logic [IDX_W-1:0] tblSize = '0;
  logic             scl;
  wire              sda;
  logic             cfgDone;
  logic             slaveLow = 1'b0;

  logic [IDX_W-1:0] romIdx = '0;
  logic [23:0]      romEntry;
  logic [IDX_W-1:0] romSize;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pullup (sda);
  assign sda = slaveLow ? 1'b0 : 1'bz;

  function automatic logic [23:0] expEntry(input int i);
    logic [7:0] a, b;
    case (i % 4)
      0:       begin a = 8'hFF; b = 8'h00; end
      1:       begin a = 8'h00; b = 8'hFF; end
      2:       begin a = 8'hA5; b = 8'h5A; end
      default: begin a = 8'(i * 19 + 1); b = 8'(~i); end
    endcase
    return {8'h34, a, b};
  endfunction

  assign tblEntry = expEntry(int'(tblIndex));

  codec_cfg_seq #(
    .CLK_HZ(50_000_000), .SCL_HZ(2_500_000), .WAIT_CYCLES(WAITC), .IDX_W(IDX_W)
  ) dut (
    .clk(clk), .rstN(rstN), .tblIndex(tblIndex), .tblEntry(tblEntry),
    .tblSize(tblSize), .scl(scl), .sda(sda), .cfgDone(cfgDone)
  );

  codec_reg_table #(.IDX_W(IDX_W)) uTable (.idx(romIdx), .entry(romEntry), .size(romSize));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard queues
  logic [7:0] expByteQ[$];
  bit         expAckQ[$];
  int         expIdxQ[$];

  task automatic planEntry(input int idx, input int nackAt);
    logic [23:0] e;
    e = expEntry(idx);
    expIdxQ.push_back(idx);
    for (int b = 0; b < 3; b++) begin
      expByteQ.push_back(e[23 - 8*b -: 8]);
      expAckQ.push_back(b != nackAt);
      if (b == nackAt) break;
    end
    if (nackAt < 3) begin
      expIdxQ.push_back(idx);
      for (int b = 0; b < 3; b++) begin
        expByteQ.push_back(e[23 - 8*b -: 8]);
        expAckQ.push_back(1'b1);
      end
    end
  endtask

  // bus monitor and acknowledging target
  int   cyc, startCount, stopCount, violations, firstStartCyc, lastRise, bitCnt;
  bit   prevScl, prevSda, ackPending, inAck, curAck;
  logic [7:0] shByte;

  always @(negedge clk) begin
    if (!rstN) begin
      cyc = 0; startCount = 0; stopCount = 0; violations = 0;
      firstStartCyc = -1; lastRise = -1; bitCnt = 0;
      prevScl = 1'b1; prevSda = 1'b1; ackPending = 1'b0; inAck = 1'b0; curAck = 1'b1;
      slaveLow = 1'b0;
    end else begin
      cyc++;
      if (scl != prevScl && sda != prevSda) violations++;   // R4
      if (prevScl && scl && prevSda && !sda) begin          // start
        startCount++;
        if (firstStartCyc < 0) firstStartCyc = cyc;
        bitCnt = 0; lastRise = -1; ackPending = 1'b0; inAck = 1'b0;
        if (expIdxQ.size() == 0) chk(1'b0, "R7", "unexpected start index", tblIndex, 0);
        else begin
          int ei;
          ei = expIdxQ.pop_front();
          chk(int'(tblIndex) == ei, "R7", "index at start (R6 retry)", tblIndex, ei);
        end
      end else if (prevScl && scl && !prevSda && sda) begin // stop
        stopCount++;
        bitCnt = 0; ackPending = 1'b0; inAck = 1'b0;
      end else if (!prevScl && scl) begin                   // rise
        if (lastRise >= 0) chk(cyc - lastRise == 4*QD, "R3", "scl period", cyc - lastRise, 4*QD);
        lastRise = cyc;
        if (inAck) begin
          if (!curAck) chk(sda == 1'b1, "R5", "sda released in ack", sda, 1);
        end else if (bitCnt < 8) begin
          shByte = {shByte[6:0], sda};
          bitCnt++;
          if (bitCnt == 8) begin
            ackPending = 1'b1;
            if (expByteQ.size() == 0) begin
              chk(1'b0, "R2", "unexpected byte", shByte, 0);
              curAck = 1'b1;
            end else begin
              logic [7:0] eb;
              eb = expByteQ.pop_front();
              curAck = expAckQ.pop_front();
              chk(shByte == eb, "R2", "byte value", shByte, eb);
            end
          end
        end
      end else if (prevScl && !scl) begin                   // fall
        if (lastRise >= 0) chk(cyc - lastRise == 2*QD, "R3", "scl high time", cyc - lastRise, 2*QD);
        if (ackPending) begin
          ackPending = 1'b0; inAck = 1'b1; slaveLow = curAck;
        end else if (inAck) begin
          inAck = 1'b0; slaveLow = 1'b0; bitCnt = 0;
        end
      end
      prevScl = scl;
      prevSda = sda;
    end
  end

  task automatic startPhase(input int size);
    @(negedge clk);
    rstN = 1'b0;
    tblSize = IDX_W'(size);
    expByteQ.delete(); expAckQ.delete(); expIdxQ.delete();
    repeat (4) @(negedge clk);
    chk(scl == 1'b1, "R1", "scl in reset", scl, 1);
    chk(sda == 1'b1, "R1", "sda in reset", sda, 1);
    chk(tblIndex == '0, "R1", "index in reset", tblIndex, 0);
    chk(cfgDone == 1'b0, "R1", "done in reset", cfgDone, 0);
  endtask

  task automatic finishPhase(input int size);
    int n, saved;
    rstN = 1'b1;
    n = 0;
    while (!cfgDone && n < 60000) begin @(negedge clk); n++; end
    chk(cfgDone == 1'b1, "R8", "done raised", cfgDone, 1);
    chk(expByteQ.size() == 0, "R2", "bytes left unsent", expByteQ.size(), 0);
    chk(expIdxQ.size() == 0, "R7", "transactions left", expIdxQ.size(), 0);
    chk(startCount == stopCount, "R2", "stop per start", stopCount, startCount);
    chk(violations == 0, "R4", "joint scl/sda changes", violations, 0);
    if (size > 0) chk(firstStartCyc >= WAITC, "R1", "first start cycle", firstStartCyc, WAITC);
    else          chk(startCount == 0, "R8", "starts with empty table", startCount, 0);
    saved = startCount;
    repeat (300) @(negedge clk);
    chk(startCount == saved, "R8", "starts after done", startCount, saved);
    chk(cfgDone == 1'b1, "R8", "done held", cfgDone, 1);
    chk(scl == 1'b1 && sda == 1'b1, "R8", "bus idle after done", {scl, sda}, 2'b11);
  endtask

  initial begin
    // R9: table contents
    for (int i = 0; i < 10; i++) begin
      romIdx = IDX_W'(i);
      #1;
      chk(romEntry[23:16] == 8'h34, "R9", "table address byte", romEntry[23:16], 8'h34);
    end
    chk(romSize == IDX_W'(10), "R9", "table size", romSize, 10);

    // six words, withheld acknowledges at three byte positions (R6)
    startPhase(6);
    planEntry(0, 3);
    planEntry(1, 3);
    planEntry(2, 1);
    planEntry(3, 3);
    planEntry(4, 0);
    planEntry(5, 2);
    finishPhase(6);

    // single word: first is also last
    startPhase(1);
    planEntry(0, 3);
    finishPhase(1);

    // empty table
    startPhase(0);
    finishPhase(0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule